// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the software-visible register set of a single DMA channel. It keeps four 32-bit registers: a control and status word, a transfer address counter, a byte count and a base-address register. Software reaches them with word accesses over a plain synchronous bus that has an address, a write enable, write data and combinational read data. The data movement itself, any address translation and the FIFO storage are outside the block. Only the flags and counters are kept here.

The device side of the channel reports a finished transfer with a one-cycle pulse and the number of bytes moved. It can also set or clear the pending-interrupt flag directly. The block produces a level interrupt and a one-cycle reset pulse for the attached peripheral.

Writes to the control word have side effects. The top nibble always holds a fixed version code. The drain bit clears itself, or becomes set when the written value is all zeros. The peripheral-reset bit fires a pulse. Writing the address register also marks the control word as "address loaded".

Top module: `dmaRegFile`

## Requirements
- R1: The register is selected by address bits [3:2] (0 control, 1 address, 2 count, 3 base). All other address bits are ignored, so an access at byte offset 0x10 reaches the same register as offset 0x00, and offset 0x14 reaches the same register as 0x04.
- R2: After reset the control word reads 0xA0000000. The other three registers read 0, and both outputs are low.
- R3: Bits [31:28] of the control word always read 0xA. A control write stores only bits [27:0] of the write data.
- R4: A control write with bit 7 set raises periphRst for exactly the cycle after the write. That write stores bits 7 and 6 as written.
- R5: A control write with bit 7 clear and bit 6 set stores bit 6 cleared.
- R6: A control write of the value zero stores 0xA0000040, which is the drain bit (bit 6) set.
- R7: Any write to the address register stores the write data and sets control bit 26 (address loaded).
- R8: A xferDone pulse adds xferLen to the address register and sets control bit 0 (interrupt pending).
- R9: A devIrqStb pulse writes devIrqLvl into control bit 0. If it arrives in the same cycle as xferDone, it takes priority for that bit.
- R10: irqOut is control bit 0 AND control bit 4 (interrupt enable). A control write with bit 4 clear makes irqOut low from the next cycle.
- R11: When a bus write and a device event update the same register in the same cycle, the bus write value is stored in that register.
- R12: The count and base registers are plain read/write storage. Reading any register has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busWe | input | 1 | Write enable for one cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data of the addressed register (combinational) |
| xferDone | input | 1 | Transfer-complete pulse from the device side |
| xferLen | input | LEN_W | Bytes moved by the completed transfer |
| devIrqStb | input | 1 | Strobe that updates the pending-interrupt flag |
| devIrqLvl | input | 1 | Value written to the pending flag on devIrqStb |
| irqOut | output | 1 | Interrupt request to the host |
| periphRst | output | 1 | One-cycle reset pulse to the peripheral |

## Verification
The hardest cases to reach are the collisions between a bus write and a device-side event in the same cycle. One is an address-register write during a completion. Another is a zero write to the control word during a completion. A third is a pending-flag strobe arriving together with a completion. The bench drives all of these inputs on one falling edge, so they land on the same rising edge. It then reads the registers back to confirm which update won. The aliasing of offset 0x10 onto offset 0x00 is covered by accesses made only through the alias address.

// File: rtl/dmaRegPkg.sv
package dmaRegPkg;
  localparam int NUM_REGS   = 4;
  localparam int IDX_CTRL   = 0;
  localparam int IDX_ADDR   = 1;
  localparam int IDX_COUNT  = 2;
  localparam int IDX_BASE   = 3;
  localparam int BIT_PEND   = 0;
  localparam int BIT_IEN    = 4;
  localparam int BIT_DRAIN  = 6;
  localparam int BIT_PRST   = 7;
  localparam int BIT_DIR    = 8;
  localparam int BIT_LOADED = 26;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrSel;
    logic                prstReq;
  } regStrobeT;
endpackage

// File: rtl/dmaRegCtrl.sv
module dmaRegCtrl
  import dmaRegPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              prstBit,
  output logic [1:0]        busIdx,
  output regStrobeT         strobe,
  output logic              periphRst
);
  // only bits [3:2] select a register; the rest alias
  assign busIdx = busAddr[3:2];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign strobe.wrSel[g] = busWe && (busIdx == 2'(g));
  end

  assign strobe.prstReq = strobe.wrSel[IDX_CTRL] && prstBit;

  always_ff @(posedge clk) begin
    if (!rstN) periphRst <= 1'b0;
    else       periphRst <= strobe.prstReq;
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.wrSel)); // R1
  AST_PRST_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr[3:2] == 2'd0 && prstBit) |=> periphRst); // R4
  AST_PRST_CAUSED: assert property (@(posedge clk) disable iff (!rstN)
    periphRst |-> $past(busWe && busAddr[3:2] == 2'd0 && prstBit)); // R4
endmodule

// File: rtl/dmaRegData.sv
module dmaRegData
  import dmaRegPkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          LEN_W   = 16,
  parameter logic [3:0]  VERSION = 4'hA
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobeT         strobe,
  input  logic [1:0]        busIdx,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              xferDone,
  input  logic [LEN_W-1:0]  xferLen,
  input  logic              devIrqStb,
  input  logic              devIrqLvl,
  output logic              irqOut
);
  localparam int VER_LO = DATA_W - 4;
  localparam logic [DATA_W-1:0] CTRL_RESET = {VERSION, {VER_LO{1'b0}}};

  logic [DATA_W-1:0] ctrlReg, ctrlNext, ctrlWrVal;
  logic [DATA_W-1:0] addrReg, addrNext;
  logic [DATA_W-1:0] plainReg [IDX_COUNT:IDX_BASE];

  // control write shaping: reset request beats drain, drain beats zero-fill
  always_comb begin
    ctrlWrVal = busWdata;
    if (busWdata[BIT_PRST]) begin
      ctrlWrVal = busWdata;
    end else if (busWdata[BIT_DRAIN]) begin
      ctrlWrVal[BIT_DRAIN] = 1'b0;
    end else if (busWdata == '0) begin
      ctrlWrVal[BIT_DRAIN] = 1'b1;
    end
    ctrlWrVal[DATA_W-1:VER_LO] = VERSION;
  end

  // event merge; bus write wins for the register it targets
  always_comb begin
    ctrlNext = ctrlReg;
    if (strobe.wrSel[IDX_ADDR]) ctrlNext[BIT_LOADED] = 1'b1;
    if (devIrqStb)              ctrlNext[BIT_PEND]   = devIrqLvl;
    else if (xferDone)          ctrlNext[BIT_PEND]   = 1'b1;
    if (strobe.wrSel[IDX_CTRL]) ctrlNext = ctrlWrVal;
  end

  always_comb begin
    addrNext = addrReg;
    if (strobe.wrSel[IDX_ADDR]) addrNext = busWdata;
    else if (xferDone)          addrNext = addrReg + DATA_W'(xferLen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= CTRL_RESET;
      addrReg <= '0;
    end else begin
      ctrlReg <= ctrlNext;
      addrReg <= addrNext;
    end
  end

  for (genvar g = IDX_COUNT; g <= IDX_BASE; g++) begin : g_plain
    always_ff @(posedge clk) begin
      if (!rstN)                plainReg[g] <= '0;
      else if (strobe.wrSel[g]) plainReg[g] <= busWdata;
    end
  end

  always_comb begin
    case (busIdx)
      2'd0:    busRdata = ctrlReg;
      2'd1:    busRdata = addrReg;
      2'd2:    busRdata = plainReg[IDX_COUNT];
      default: busRdata = plainReg[IDX_BASE];
    endcase
  end

  assign irqOut = ctrlReg[BIT_PEND] & ctrlReg[BIT_IEN];

  AST_VERSION_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[DATA_W-1:VER_LO] == VERSION); // R3
  AST_LOADED_SET: assert property (@(posedge clk) disable iff (!rstN)
    (busIdx == 2'd1 && strobe.wrSel != '0) |=> ctrlReg[BIT_LOADED]); // R7
  AST_DRAIN_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrSel[IDX_CTRL] && !busWdata[BIT_PRST] && busWdata[BIT_DRAIN])
    |=> !ctrlReg[BIT_DRAIN]); // R5
  AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && !strobe.wrSel[IDX_ADDR])
    |=> addrReg == $past(addrReg) + DATA_W'($past(xferLen))); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrSel[IDX_CTRL] && !busWdata[BIT_IEN]) |=> !irqOut); // R10
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrSel[IDX_ADDR] |=> addrReg == $past(busWdata)); // R11
endmodule

// File: rtl/dmaRegFile.sv
module dmaRegFile
  import dmaRegPkg::*;
#(
  parameter int         ADDR_W  = 8,
  parameter int         LEN_W   = 16,
  parameter logic [3:0] VERSION = 4'hA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              xferDone,
  input  logic [LEN_W-1:0]  xferLen,
  input  logic              devIrqStb,
  input  logic              devIrqLvl,
  output logic              irqOut,
  output logic              periphRst
);
  regStrobeT strobe;
  logic [1:0] busIdx;

  dmaRegCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .prstBit(busWdata[BIT_PRST]), .busIdx(busIdx), .strobe(strobe),
    .periphRst(periphRst)
  );

  dmaRegData #(.DATA_W(32), .LEN_W(LEN_W), .VERSION(VERSION)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busIdx(busIdx),
    .busWdata(busWdata), .busRdata(busRdata), .xferDone(xferDone),
    .xferLen(xferLen), .devIrqStb(devIrqStb), .devIrqLvl(devIrqLvl),
    .irqOut(irqOut)
  );
endmodule

// File: tb/dmaRegFile_bench.sv
module dmaRegFile_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        xferDone = 1'b0;
  logic [15:0] xferLen = '0;
  logic        devIrqStb = 1'b0;
  logic        devIrqLvl = 1'b0;
  logic        irqOut, periphRst;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dmaRegFile u_dmaRegFile (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .xferDone(xferDone),
    .xferLen(xferLen), .devIrqStb(devIrqStb), .devIrqLvl(devIrqLvl),
    .irqOut(irqOut), .periphRst(periphRst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // one clock with any mix of bus write and device events, driven on a falling edge
  task automatic drive(input logic we, input logic [7:0] a, input logic [31:0] d,
                       input logic done, input logic [15:0] len,
                       input logic stb, input logic lvl);
    busWe = we; busAddr = a; busWdata = d;
    xferDone = done; xferLen = len; devIrqStb = stb; devIrqLvl = lvl;
    @(negedge clk);
    busWe = 1'b0; xferDone = 1'b0; devIrqStb = 1'b0; devIrqLvl = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    drive(1'b1, a, d, 1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    busAddr = a;
    #1 v = busRdata;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] v;
    doReset();
    rd(8'h00, v); chk("R2 ctrl", v, 32'hA000_0000);
    rd(8'h04, v); chk("R2 addr", v, 32'h0);
    rd(8'h08, v); chk("R2 count", v, 32'h0);
    rd(8'h0C, v); chk("R2 base", v, 32'h0);
    chk("R2 irqOut", {31'b0, irqOut}, 32'h0);
    chk("R2 periphRst", {31'b0, periphRst}, 32'h0);
  endtask

  task automatic testAlias();
    logic [31:0] v;
    doReset();
    wr(8'h14, 32'h0000_1234);
    rd(8'h04, v); chk("R1 alias addr", v, 32'h0000_1234);
    rd(8'h10, v); chk("R1 alias ctrl", v, 32'hA400_0000);
    wr(8'hF8, 32'h0BAD_F00D);
    rd(8'h08, v); chk("R1 high bits ignored", v, 32'h0BAD_F00D);
  endtask

  task automatic testCtrlWrites();
    logic [31:0] v;
    doReset();
    wr(8'h00, 32'h5000_0010);
    rd(8'h00, v); chk("R3 version forced", v, 32'hA000_0010);
    wr(8'h00, 32'h0000_0050);
    rd(8'h00, v); chk("R5 drain cleared", v, 32'hA000_0010);
    wr(8'h00, 32'h0);
    rd(8'h00, v); chk("R6 zero write", v, 32'hA000_0040);
    chk("R4 no pulse", {31'b0, periphRst}, 32'h0);
    wr(8'h00, 32'hF000_01C0);
    chk("R4 pulse high", {31'b0, periphRst}, 32'h1);
    rd(8'h00, v); chk("R4 bits kept", v, 32'hA000_01C0);
    @(negedge clk);
    chk("R4 pulse one cycle", {31'b0, periphRst}, 32'h0);
  endtask

  task automatic testIrq();
    logic [31:0] v;
    doReset();
    wr(8'h00, 32'h0000_0010);
    drive(1'b0, 8'h00, 32'h0, 1'b0, '0, 1'b1, 1'b1);
    rd(8'h00, v); chk("R9 pend set", v, 32'hA000_0011);
    chk("R10 irq on", {31'b0, irqOut}, 32'h1);
    wr(8'h00, 32'h0000_0001);
    chk("R10 irq masked", {31'b0, irqOut}, 32'h0);
    wr(8'h00, 32'h0000_0011);
    chk("R10 irq back", {31'b0, irqOut}, 32'h1);
    drive(1'b0, 8'h00, 32'h0, 1'b0, '0, 1'b1, 1'b0);
    rd(8'h00, v); chk("R9 pend clear", v, 32'hA000_0010);
    chk("R9 irq off", {31'b0, irqOut}, 32'h0);
    drive(1'b0, 8'h00, 32'h0, 1'b1, 16'h4, 1'b1, 1'b0);
    rd(8'h00, v); chk("R9 strobe beats done", v, 32'hA000_0010);
  endtask

  task automatic testDone();
    logic [31:0] v;
    doReset();
    wr(8'h04, 32'h0000_0100);
    drive(1'b0, 8'h00, 32'h0, 1'b1, 16'h0020, 1'b0, 1'b0);
    rd(8'h04, v); chk("R8 addr advance", v, 32'h0000_0120);
    rd(8'h00, v); chk("R8 pend set", v, 32'hA400_0001);
    drive(1'b0, 8'h00, 32'h0, 1'b1, 16'hFFFF, 1'b0, 1'b0);
    rd(8'h04, v); chk("R8 large len", v, 32'h0001_011F);
  endtask

  task automatic testCollide();
    logic [31:0] v;
    doReset();
    drive(1'b1, 8'h04, 32'h0000_0500, 1'b1, 16'h0008, 1'b0, 1'b0);
    rd(8'h04, v); chk("R11 addr write wins", v, 32'h0000_0500);
    rd(8'h00, v); chk("R11 ctrl from both", v, 32'hA400_0001);
    drive(1'b1, 8'h00, 32'h0, 1'b1, 16'h0008, 1'b0, 1'b0);
    rd(8'h00, v); chk("R11 ctrl write wins", v, 32'hA000_0040);
    rd(8'h04, v); chk("R11 addr still advanced", v, 32'h0000_0508);
  endtask

  task automatic testPlain();
    logic [31:0] v;
    doReset();
    wr(8'h08, 32'hDEAD_BEEF);
    wr(8'h0C, 32'h1357_9BDF);
    rd(8'h08, v); chk("R12 count", v, 32'hDEAD_BEEF);
    rd(8'h0C, v); chk("R12 base", v, 32'h1357_9BDF);
    @(negedge clk);
    rd(8'h0C, v); chk("R12 reread base", v, 32'h1357_9BDF);
    rd(8'h00, v); chk("R12 ctrl untouched", v, 32'hA000_0000);
    rd(8'h04, v); chk("R12 addr untouched", v, 32'h0);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testAlias();
    testCtrlWrites();
    testIrq();
    testDone();
    testCollide();
    testPlain();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule